// File: doc/BRIEF.md
# Guarded Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. It multiplies two signed 17-bit operands at full precision. Depending on the opcode, it loads the product into a 40-bit accumulator, adds it to the accumulator, or subtracts it. The accumulator holds a 32-bit value field with 8 guard bits above it. Long sums can therefore grow past the 32-bit range without losing information.

Saturation is not automatic. A dedicated opcode clamps the accumulator back into the signed 32-bit range when software decides the sum is complete. Beside the accumulator, a one-cycle exponent encoder counts the redundant sign bits of the accumulator. That count is the shift a normalizer would need, which supports block-floating-point scaling.

Every operation is qualified by a valid strobe. Its result appears on the outputs one clock after the strobed edge.

Top module: `dsp_mac_guard`

## Requirements
- R1: After reset, `acc_q` is 0 and `exp_q` is 0.
- R2: With `in_valid` high and `op_in` = 0 (clear), `acc_q` becomes 0 after the next rising clock edge.
- R3: With `in_valid` high and `op_in` = 1 (load), `acc_q` becomes the signed product `a_in*b_in`, sign-extended to 40 bits, after the next edge.
- R4: With `in_valid` high and `op_in` = 2 (accumulate), `acc_q` becomes its previous value plus the sign-extended product after the next edge.
- R5: With `in_valid` high and `op_in` = 3 (subtract), `acc_q` becomes its previous value minus the sign-extended product after the next edge.
- R6: With `in_valid` high and `op_in` = 4 (saturate), the clamp depends on the previous `acc_q`:
  - a value above 2^31-1 becomes 0x007FFFFFFF;
  - a value below -2^31 becomes 0xFF80000000;
  - any other value is kept.
- R7: With `in_valid` high and `op_in` = 5 (exponent), `exp_q` takes the count of redundant sign bits in `acc_q`, and `acc_q` is unchanged.
  - The count is the number of consecutive bits, starting at bit 38 and moving down, that equal bit 39.
  - The count is 39 when the accumulator is all zeros or all ones.
- R8: When `in_valid` is low, or `op_in` is 6 or 7, neither `acc_q` nor `exp_q` changes. `exp_q` also holds under every opcode other than 5.
- R9: Accumulation wraps in 40-bit two's complement when the sum exceeds the guard range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies op_in, a_in and b_in for this cycle |
| op_in | input | 3 | Operation code (0 clear, 1 load, 2 accumulate, 3 subtract, 4 saturate, 5 exponent) |
| a_in | input | 17 | Signed multiplicand |
| b_in | input | 17 | Signed multiplier |
| acc_q | output | 40 | Accumulator: 8 guard bits over a 32-bit value |
| exp_q | output | 6 | Latched redundant-sign-bit count |

## Verification
The bench builds the unit with its default widths: 17-bit operands, a 32-bit value field and 8 guard bits. With these widths the largest product, (-65536)*(-65536) = 2^32, already lies outside the 32-bit range. A hundred such accumulations stay exact inside the guard bits, and forty more wrap the 40-bit register. Each of these cases can therefore be reached in a few hundred cycles. The same products produce exponent counts far from both ends of the 0..39 range.

// File: rtl/dsp_mac_guard.sv
module dsp_mac_guard #(
  parameter int IN_W  = 17,
  parameter int VAL_W = 32,
  parameter int GRD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [2:0]                    op_in,
  input  logic [IN_W-1:0]               a_in,
  input  logic [IN_W-1:0]               b_in,
  output logic [VAL_W+GRD_W-1:0]        acc_q,
  output logic [$clog2(VAL_W+GRD_W)-1:0] exp_q
);
  localparam int ACC_W  = VAL_W + GRD_W;
  localparam int PROD_W = 2 * IN_W;
  localparam int EXT_W  = ACC_W - PROD_W;
  localparam int EXP_W  = $clog2(ACC_W);

  localparam logic [2:0] OP_CLR = 3'd0;
  localparam logic [2:0] OP_LD  = 3'd1;
  localparam logic [2:0] OP_MAC = 3'd2;
  localparam logic [2:0] OP_MSU = 3'd3;
  localparam logic [2:0] OP_SAT = 3'd4;
  localparam logic [2:0] OP_EXP = 3'd5;

  localparam logic [ACC_W-1:0] SAT_HI = {{(GRD_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_LO = {{(GRD_W+1){1'b1}}, {(VAL_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0] prod_x, acc_d, sat_v;
  logic [EXP_W-1:0] rsb;
  logic in_rng;

  assign prod   = $signed(a_in) * $signed(b_in);
  assign prod_x = {{EXT_W{prod[PROD_W-1]}}, prod};

  assign in_rng = (acc_q[ACC_W-1:VAL_W-1] == '0) || (acc_q[ACC_W-1:VAL_W-1] == '1);
  assign sat_v  = in_rng ? acc_q : (acc_q[ACC_W-1] ? SAT_LO : SAT_HI);

  always_comb begin
    logic done;
    rsb  = '0;
    done = 1'b0;
    for (int i = ACC_W - 2; i >= 0; i--) begin
      if (!done) begin
        if (acc_q[i] == acc_q[ACC_W-1]) rsb = rsb + 1'b1;
        else done = 1'b1;
      end
    end
  end

  always_comb begin
    acc_d = acc_q;
    case (op_in)
      OP_CLR: acc_d = '0;
      OP_LD:  acc_d = prod_x;
      OP_MAC: acc_d = acc_q + prod_x;
      OP_MSU: acc_d = acc_q - prod_x;
      OP_SAT: acc_d = sat_v;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      exp_q <= '0;
    end else if (in_valid) begin
      acc_q <= acc_d;
      if (op_in == OP_EXP) exp_q <= rsb;
    end
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_in == OP_CLR) |=> (acc_q == '0));

  // R4
  mac_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_in == OP_MAC) |=> (acc_q == $past(acc_q) + $past(prod_x)));

  // R6
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_in == OP_SAT) |=>
      ($signed(acc_q) <= $signed(SAT_HI) && $signed(acc_q) >= $signed(SAT_LO)));

  // R7
  exp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_in == OP_EXP) |=> $stable(acc_q));

  // R7
  exp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q <= EXP_W'(ACC_W - 1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_q) && $stable(exp_q)));

endmodule

// File: tb/dsp_mac_guard_tb.sv
module dsp_mac_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [2:0] op_in = '0;
  logic signed [16:0] a_in = '0, b_in = '0;
  logic [39:0] acc_q;
  logic [5:0] exp_q;

  int n_chk = 0, n_bad = 0;
  logic signed [39:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_mac_guard dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
    .a_in(a_in), .b_in(b_in), .acc_q(acc_q), .exp_q(exp_q));

  task automatic chk_acc(input string req, input logic [39:0] exp_v);
    n_chk++;
    if (acc_q !== exp_v) begin
      n_bad++;
      $display("FAIL %s acc actual=%h expected=%h", req, acc_q, exp_v);
    end
  endtask

  task automatic chk_exp(input string req, input logic [5:0] exp_v);
    n_chk++;
    if (exp_q !== exp_v) begin
      n_bad++;
      $display("FAIL %s exp actual=%0d expected=%0d", req, exp_q, exp_v);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic signed [16:0] a,
                       input logic signed [16:0] b, input logic v = 1'b1);
    logic signed [39:0] p;
    p = a * b;
    op_in = op; a_in = a; b_in = b; in_valid = v;
    @(negedge clk);
    in_valid = 1'b0;
    if (v) begin
      case (op)
        3'd0: model = '0;
        3'd1: model = p;
        3'd2: model = model + p;
        3'd3: model = model - p;
        default: ;
      endcase
    end
  endtask

  task automatic t_reset;
    chk_acc("R1", 40'h0);
    chk_exp("R1", 6'd0);
  endtask

  task automatic t_load;
    do_op(3'd1, -17'sd65536, -17'sd65536);
    chk_acc("R3", 40'h01_0000_0000);
    do_op(3'd1, 17'sd65535, -17'sd3);
    chk_acc("R3", 40'hFF_FFFD_0003);
    do_op(3'd0, 17'sd5, 17'sd5);
    chk_acc("R2", 40'h0);
  endtask

  task automatic t_mac_wrap;
    do_op(3'd0, 0, 0);
    for (int i = 0; i < 101; i++) do_op(3'd2, -17'sd65536, -17'sd65536);
    chk_acc("R4", 40'd101 << 32);
    do_op(3'd2, 17'sd300, -17'sd7);
    chk_acc("R4", model);
    for (int i = 0; i < 40; i++) do_op(3'd2, -17'sd65536, -17'sd65536);
    chk_acc("R9", model);
    chk_acc("R9", (40'd141 << 32) - 40'd2100);
  endtask

  task automatic t_msu;
    do_op(3'd1, 17'sd1000, 17'sd1000);
    do_op(3'd3, 17'sd2000, 17'sd1000);
    chk_acc("R5", -40'sd1000000);
    do_op(3'd3, -17'sd4, 17'sd250);
    chk_acc("R5", model);
  endtask

  task automatic t_sat;
    do_op(3'd1, -17'sd65536, -17'sd65536);
    do_op(3'd4, 0, 0);
    chk_acc("R6", 40'h00_7FFF_FFFF);
    do_op(3'd1, -17'sd65536, 17'sd65535);
    do_op(3'd3, 17'sd65535, 17'sd65535);
    do_op(3'd4, 0, 0);
    chk_acc("R6", 40'hFF_8000_0000);
    do_op(3'd1, 17'sd1234, -17'sd99);
    do_op(3'd4, 0, 0);
    chk_acc("R6", model);
  endtask

  task automatic t_exp;
    do_op(3'd1, 17'sd1, 17'sd1);
    do_op(3'd5, 0, 0);
    chk_exp("R7", 6'd38);
    chk_acc("R7", 40'h1);
    do_op(3'd0, 0, 0);
    do_op(3'd5, 0, 0);
    chk_exp("R7", 6'd39);
    do_op(3'd1, -17'sd1, 17'sd1);
    do_op(3'd5, 0, 0);
    chk_exp("R7", 6'd39);
    do_op(3'd1, -17'sd1, 17'sd2);
    do_op(3'd5, 0, 0);
    chk_exp("R7", 6'd38);
    do_op(3'd1, -17'sd65536, -17'sd65536);
    do_op(3'd5, 0, 0);
    chk_exp("R7", 6'd6);
  endtask

  task automatic t_hold;
    do_op(3'd1, 17'sd77, 17'sd3);
    do_op(3'd2, 17'sd500, 17'sd500, 1'b0);
    chk_acc("R8", 40'd231);
    do_op(3'd6, 17'sd500, 17'sd500);
    chk_acc("R8", 40'd231);
    do_op(3'd7, 17'sd500, 17'sd500);
    chk_acc("R8", 40'd231);
    do_op(3'd2, 17'sd9, 17'sd9);
    chk_exp("R8", 6'd6);
    do_op(3'd5, 0, 0, 1'b0);
    chk_exp("R8", 6'd6);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_mac_wrap();
        t_msu();
        t_sat();
        t_exp();
        t_hold();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule